// File: doc/BRIEF.md
# Airtime Credit Transmit Gate

This block decides whether a radio frame may go on air. It keeps an airtime budget in 10 ms units. Each request carries the frame's length byte and a flag that asks for a one-second wake-up preamble. The gate prices the request from those two inputs and compares the price with the budget that remains. A request it can afford is granted and its price is deducted. A request it cannot afford is refused with an overflow pulse, and the budget is left as it was.

After a grant, the gate holds the start of transmission until a minimum quiet interval has passed since the previous frame ended. It measures that interval with a slow free-running system tick, and the measurement stays correct when the tick counter wraps. It then pulses a start-transmit strobe. For a long-preamble frame it keeps the carrier on for one second's worth of ticks before it signals that payload may be loaded. When the radio reports that the frame has finished, the gate stores the tick of that moment for the next quiet-interval check. A separate strobe adds one unit of credit at a time, up to a ceiling.

Top module: `airtime_gate`

## Requirements
- R1: The price in 10 ms units is PRE_COST (default 100) when the long-preamble flag is set, plus ((length byte + 1) × 8) / BITS_PER_UNIT (default 10) with integer division. All 8 bits of the length byte count, so length 0 costs 0 and length 255 with preamble costs 304.
- R2: A request whose price exceeds the credit is refused. One cycle later resp_valid and resp_ovf are high and resp_grant is low, the credit is not reduced, and no transmission starts. A price equal to the credit is granted.
- R3: A request sampled while the gate is idle is answered one cycle later with a one-cycle resp_valid. On a grant, resp_grant is high and the credit shows the deduction in that same cycle.
- R4: Each refill strobe adds one unit to the credit, and the credit never exceeds CREDIT_MAX. When a refill and a grant deduction fall on the same edge, both take effect: the new credit is old − price + 1, capped at CREDIT_MAX.
- R5: After reset the credit equals CREDIT_MAX, every response and strobe output is low, busy is low, and no previous transmission is recorded.
- R6: After a grant, tx_start is withheld on every edge where the tick minus the recorded last-send tick, taken modulo 2^TICK_W, is below GAP_TICKS (default 2: the tick equals the last-send tick or the last-send tick + 1). This holds across the wrap from 255 to 0.
- R7: A recorded last-send tick of zero counts as "no previous transmission", and tx_start then follows on the first edge after the grant.
- R8: Without the preamble, tx_load pulses one cycle after tx_start. With the preamble, tx_load pulses on the first edge where the tick has moved at least PRE_TICKS (default 125, one second at 8 ms per tick) beyond its value at the tx_start edge.
- R9: tx_done, when seen after tx_load, records the current tick as the last-send tick and returns the gate to idle (busy low).
- R10: A request presented while busy is high gets no response and leaves the credit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle transmit request |
| req_len | input | LEN_W | Frame length byte |
| req_long | input | 1 | Request the one-second wake-up preamble |
| refill | input | 1 | Add one credit unit |
| sys_tick | input | TICK_W | Free-running slow tick counter (8 ms per step) |
| tx_done | input | 1 | Radio reports the frame is finished |
| resp_valid | output | 1 | Response to a request is present |
| resp_grant | output | 1 | Request granted and price deducted |
| resp_ovf | output | 1 | Request refused: credit too low |
| tx_start | output | 1 | Pulse: switch the transmitter on |
| tx_load | output | 1 | Pulse: payload may now be loaded |
| busy | output | 1 | A granted transmission is in progress |
| credit | output | CREDIT_W | Remaining airtime credit |

## Verification
Two of the block's functions can act on the credit on the same clock edge: the refill increment and the deduction made by a grant. The bench provokes this with a directed case that drains the credit to exactly zero and then raises refill in the cycle of a zero-price request. It also does so throughout a random phase, where refill strobes fall at random against random requests. On every edge it compares the credit with a model that applies old − price + 1 with the cap, so a lost increment, a lost deduction or a missed cap shows up as a miscompare on that cycle.

// File: rtl/airtime_pkg.sv
// Package airtime_pkg
// Shared types for the airtime credit gate.
package airtime_pkg;

    // Sequencer states of the transmit gate.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_GAP  = 2'd1,   // granted, waiting for the quiet interval
        ST_TXON = 2'd2,   // carrier on, preamble running
        ST_WAIT = 2'd3    // payload loaded, waiting for completion
    } gate_state_e;

endpackage

// File: rtl/airtime_cost.sv
// Module airtime_cost
// Prices a frame in 10 ms airtime units: preamble surcharge plus the
// length-derived bit time divided by the bits per unit.
// Assumes: purely combinational; COST_W is wide enough for the largest price.
module airtime_cost #(
    parameter int LEN_W         = 8,
    parameter int PRE_COST      = 100,
    parameter int BITS_PER_UNIT = 10,
    parameter int COST_W        = 9
) (
    input  logic [LEN_W-1:0]  len,
    input  logic              long_pre,
    output logic [COST_W-1:0] cost
);
    localparam int BIT_W = LEN_W + 4;

    logic [BIT_W-1:0] bit_time;
    logic [BIT_W-1:0] len_units;

    // Bit time of the frame including its length byte, then scaled to units.
    always_comb begin
        bit_time  = (BIT_W'(len) + BIT_W'(1)) << 3;
        len_units = bit_time / BIT_W'(BITS_PER_UNIT);
        cost      = COST_W'(len_units) + (long_pre ? COST_W'(PRE_COST) : COST_W'(0));
    end

endmodule

// File: rtl/airtime_credit.sv
// Module airtime_credit
// Holds the airtime budget. A grant subtracts the price, a refill strobe
// adds one unit, and the result saturates at CREDIT_MAX.
// Assumes: deduct is only raised when enough is high, so no underflow.
module airtime_credit #(
    parameter int CREDIT_MAX = 3600,
    parameter int CREDIT_W   = 12,
    parameter int COST_W     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refill,
    input  logic                deduct,
    input  logic [COST_W-1:0]   cost,
    output logic                enough,
    output logic [CREDIT_W-1:0] credit
);
    localparam int CALC_W = ((CREDIT_W > COST_W) ? CREDIT_W : COST_W) + 1;
    localparam logic [CALC_W-1:0] CAP = CALC_W'(CREDIT_MAX);

    logic [CALC_W-1:0] after_ded;
    logic [CALC_W-1:0] after_add;
    logic [CREDIT_W-1:0] credit_nxt;

    // Affordability test against the current credit.
    always_comb enough = CALC_W'(credit) >= CALC_W'(cost);

    // Next credit: apply deduction and refill together, then cap.
    always_comb begin
        after_ded  = CALC_W'(credit) - (deduct ? CALC_W'(cost) : CALC_W'(0));
        after_add  = after_ded + CALC_W'(refill);
        credit_nxt = (after_add > CAP) ? CREDIT_W'(CREDIT_MAX) : CREDIT_W'(after_add);
    end

    // Credit register, full budget after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) credit <= CREDIT_W'(CREDIT_MAX);
        else        credit <= credit_nxt;
    end

    // R4: the budget never passes its ceiling.
    p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        CALC_W'(credit) <= CAP);

    // R4: a lone refill below the ceiling raises the credit by one.
    p_refill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !deduct && CALC_W'(credit) < CAP) |=> CALC_W'(credit) == CALC_W'($past(credit)) + CALC_W'(1));

    // R2: without a deduction the credit never falls.
    p_no_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !deduct |=> credit >= $past(credit));

endmodule

// File: rtl/airtime_gap.sv
// Module airtime_gap
// Remembers the tick at which the last frame ended and reports whether the
// quiet interval has passed. Works on the modular tick difference, so a
// wrapping tick counter is handled without special cases.
// Assumes: a stored tick of zero means no previous transmission.
module airtime_gap #(
    parameter int TICK_W    = 8,
    parameter int GAP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] sys_tick,
    input  logic              record,
    output logic              clear,
    output logic [TICK_W-1:0] last_tick
);
    localparam logic [TICK_W-1:0] GAP_LIM = TICK_W'(GAP_TICKS);

    logic [TICK_W-1:0] since;

    // Quiet interval test on the wrapped difference.
    always_comb begin
        since = sys_tick - last_tick;
        clear = (last_tick == '0) || (since >= GAP_LIM);
    end

    // Last-send tick register, captured when a frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_tick <= '0;
        else if (record) last_tick <= sys_tick;
    end

    // R9: completion stores the tick seen on that edge.
    p_record_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        record |=> last_tick == $past(sys_tick));

    // R9: the stored tick only moves on completion.
    p_hold_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !record |=> $stable(last_tick));

endmodule

// File: rtl/airtime_gate.sv
// Module airtime_gate
// Admits or refuses transmit requests against an airtime credit, enforces
// the quiet interval after the previous frame, times the optional wake-up
// preamble and records when each frame ends.
// Assumes: sys_tick advances slowly (8 ms per step) relative to clk;
// PRE_TICKS < 2**TICK_W; tx_done is only meaningful after tx_load.
module airtime_gate #(
    parameter int LEN_W         = 8,
    parameter int TICK_W        = 8,
    parameter int CREDIT_MAX    = 3600,
    parameter int PRE_COST      = 100,
    parameter int BITS_PER_UNIT = 10,
    parameter int GAP_TICKS     = 2,
    parameter int PRE_TICKS     = 125,
    localparam int CREDIT_W     = $clog2(CREDIT_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LEN_W-1:0]    req_len,
    input  logic                req_long,
    input  logic                refill,
    input  logic [TICK_W-1:0]   sys_tick,
    input  logic                tx_done,
    output logic                resp_valid,
    output logic                resp_grant,
    output logic                resp_ovf,
    output logic                tx_start,
    output logic                tx_load,
    output logic                busy,
    output logic [CREDIT_W-1:0] credit
);
    import airtime_pkg::*;

    localparam int MAX_COST = PRE_COST + ((2 ** LEN_W) * 8) / BITS_PER_UNIT;
    localparam int COST_W   = $clog2(MAX_COST + 1);
    localparam logic [TICK_W-1:0] PRE_LIM = TICK_W'(PRE_TICKS);
    localparam logic [TICK_W-1:0] GAP_LIM = TICK_W'(GAP_TICKS);

    gate_state_e       state;
    logic [COST_W-1:0] cost;
    logic              enough;
    logic              grant_now;
    logic              gap_clear;
    logic [TICK_W-1:0] last_tick;
    logic [TICK_W-1:0] start_tick;
    logic [TICK_W-1:0] elapsed;
    logic              long_q;
    logic              record;

    airtime_cost #(
        .LEN_W(LEN_W), .PRE_COST(PRE_COST),
        .BITS_PER_UNIT(BITS_PER_UNIT), .COST_W(COST_W)
    ) i_cost (
        .len(req_len), .long_pre(req_long), .cost(cost)
    );

    airtime_credit #(
        .CREDIT_MAX(CREDIT_MAX), .CREDIT_W(CREDIT_W), .COST_W(COST_W)
    ) i_credit (
        .clk(clk), .rst_n(rst_n), .refill(refill), .deduct(grant_now),
        .cost(cost), .enough(enough), .credit(credit)
    );

    airtime_gap #(
        .TICK_W(TICK_W), .GAP_TICKS(GAP_TICKS)
    ) i_gap (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .record(record),
        .clear(gap_clear), .last_tick(last_tick)
    );

    // Decode of the current-cycle events.
    always_comb begin
        grant_now = req_valid && (state == ST_IDLE) && enough;
        record    = tx_done && (state == ST_WAIT);
        elapsed   = sys_tick - start_tick;
        busy      = (state != ST_IDLE);
    end

    // Sequencer: request, quiet interval, preamble, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            long_q     <= 1'b0;
            start_tick <= '0;
        end else begin
            case (state)
                ST_IDLE: if (grant_now) begin
                    state  <= ST_GAP;
                    long_q <= req_long;
                end
                ST_GAP: if (gap_clear) begin
                    state      <= ST_TXON;
                    start_tick <= sys_tick;
                end
                ST_TXON: if (!long_q || elapsed >= PRE_LIM) state <= ST_WAIT;
                ST_WAIT: if (tx_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Registered one-cycle response and transmit strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_grant <= 1'b0;
            resp_ovf   <= 1'b0;
            tx_start   <= 1'b0;
            tx_load    <= 1'b0;
        end else begin
            resp_valid <= req_valid && (state == ST_IDLE);
            resp_grant <= grant_now;
            resp_ovf   <= req_valid && (state == ST_IDLE) && !enough;
            tx_start   <= (state == ST_GAP) && gap_clear;
            tx_load    <= (state == ST_TXON) && (!long_q || elapsed >= PRE_LIM);
        end
    end

    // R3: every response answers a request of the previous cycle.
    p_resp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid));

    // R2: grant and refusal never coincide.
    p_grant_xor_ovf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_grant, resp_ovf}));

    // R2: a refusal leaves the gate idle.
    p_refuse_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ovf |-> !busy);

    // R6: transmission only starts once the quiet interval has elapsed.
    p_start_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (last_tick == '0) || (TICK_W'($past(sys_tick) - last_tick) >= GAP_LIM));

    // R8: payload is never released in the cycle the carrier starts.
    p_load_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_load);

    // R10: a request while busy draws no response.
    p_busy_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> !resp_valid);

endmodule

// File: tb/test_airtime_gate.sv
module test_airtime_gate;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 500;
    localparam int PRE        = 125;
    localparam int CW         = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    req_len = 8'd0;
    logic          req_long = 1'b0;
    logic          refill = 1'b0;
    logic [7:0]    sys_tick = 8'd0;
    logic          tx_done = 1'b0;
    logic          resp_valid, resp_grant, resp_ovf, tx_start, tx_load, busy;
    logic [CW-1:0] credit;

    airtime_gate #(.CREDIT_MAX(MAXC), .PRE_TICKS(PRE)) i_airtime_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_long(req_long), .refill(refill), .sys_tick(sys_tick),
        .tx_done(tx_done), .resp_valid(resp_valid), .resp_grant(resp_grant),
        .resp_ovf(resp_ovf), .tx_start(tx_start), .tx_load(tx_load),
        .busy(busy), .credit(credit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int exp_credit = MAXC;
    int ded = 0;
    int exp_last = 0;
    bit tick_auto = 1'b0;
    bit rnd_refill = 1'b0;
    int div_cnt = 0;

    function automatic int cost_of(int len, bit lng);
        return (lng ? 100 : 0) + ((len + 1) * 8) / 10;
    endfunction

    function automatic bit gap_ok(logic [7:0] t);
        return (exp_last == 0) || (8'(t - 8'(exp_last)) >= 8'd2);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: update the model at the edge, sample 1 time unit later.
    task automatic cyc();
        @(posedge clk);
        exp_credit = exp_credit - ded + (refill ? 1 : 0);
        if (exp_credit > MAXC) exp_credit = MAXC;
        ded = 0;
        #1;
        if (rst_n) chk("R4 credit", int'(credit), exp_credit);
        refill = rnd_refill ? ($urandom % 4 == 0) : 1'b0;
        if (tick_auto) begin
            div_cnt++;
            if (div_cnt == 2) begin
                div_cnt = 0;
                sys_tick = sys_tick + 8'd1;
            end
        end
    endtask

    task automatic request(int len, bit lng, output bit granted);
        int c;
        c = cost_of(len, lng);
        granted = (exp_credit >= c);
        req_valid = 1'b1;
        req_len = 8'(len);
        req_long = lng;
        if (granted) ded = c;
        cyc();
        req_valid = 1'b0;
        chk("R3 resp_valid", int'(resp_valid), 1);
        chk("R3 resp_grant", int'(resp_grant), int'(granted));
        chk("R2 resp_ovf", int'(resp_ovf), int'(!granted));
        if (!granted) chk("R2 busy after refusal", int'(busy), 0);
    endtask

    // Follow a granted frame through gap, preamble and completion.
    task automatic finish_tx(bit lng, int done_delay, bit poke_busy, int done_tick);
        bit ok;
        int held = 0;
        logic [7:0] st;
        forever begin
            if (!tick_auto && held == 3) begin
                sys_tick = sys_tick + 8'd1;
                held = 0;
            end
            ok = gap_ok(sys_tick);
            st = sys_tick;
            cyc();
            chk(exp_last == 0 ? "R7 tx_start" : "R6 tx_start", int'(tx_start), int'(ok));
            if (ok) break;
            held++;
        end
        forever begin
            if (!tick_auto && lng) sys_tick = sys_tick + 8'd1;
            ok = !lng || (8'(sys_tick - st) >= 8'(PRE));
            cyc();
            chk("R8 tx_load", int'(tx_load), int'(ok));
            if (ok) break;
        end
        if (poke_busy) begin
            req_valid = 1'b1;
            req_len = 8'd3;
            req_long = 1'b0;
            cyc();
            req_valid = 1'b0;
            chk("R10 no response while busy", int'(resp_valid), 0);
        end
        repeat (done_delay) cyc();
        if (done_tick >= 0) sys_tick = 8'(done_tick);
        tx_done = 1'b1;
        st = sys_tick;
        cyc();
        tx_done = 1'b0;
        exp_last = int'(st);
        chk("R9 idle after done", int'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit g;
        void'($urandom(32'd20240607));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R5: reset state
        chk("R5 credit", int'(credit), MAXC);
        chk("R5 resp_valid", int'(resp_valid), 0);
        chk("R5 tx_start", int'(tx_start), 0);
        chk("R5 tx_load", int'(tx_load), 0);
        chk("R5 busy", int'(busy), 0);

        // R1 directed prices, R7 no previous send (tick held at 0)
        request(0, 1'b0, g);   // price 0
        finish_tx(1'b0, 2, 1'b0, 0);
        request(0, 1'b0, g);   // last tick 0: no gap wait (R7)
        finish_tx(1'b0, 1, 1'b1, 40);
        request(1, 1'b0, g);   // price 1, gap from tick 40 (R6)
        finish_tx(1'b0, 1, 1'b0, 255);
        request(9, 1'b0, g);   // price 8, wrap 255 -> 0 -> 1 (R6)
        finish_tx(1'b0, 0, 1'b0, 100);
        request(255, 1'b1, g); // price 304 with preamble (R1, R8)
        finish_tx(1'b1, 2, 1'b0, 7);

        // R2 refusal and exact-credit boundary; now 500-0-0-1-8-304 = 187
        request(255, 1'b1, g); // 304 > 187: refused
        request(232, 1'b0, g); // (233*8)/10 = 186
        finish_tx(1'b0, 0, 1'b0, 20);
        request(0, 1'b1, g);   // price 100 > 1: refused
        request(1, 1'b0, g);   // price 1 == credit 1: granted
        finish_tx(1'b0, 0, 1'b0, 30);
        request(1, 1'b0, g);   // credit 0: refused
        // R4 refill and deduction on one edge: 0 - 0 + 1
        refill = 1'b1;
        request(0, 1'b0, g);
        finish_tx(1'b0, 0, 1'b0, 50);

        // R4 saturation: refill while full
        repeat (MAXC + 20) begin
            refill = 1'b1;
            cyc();
        end
        chk("R4 saturated", int'(credit), MAXC);

        // Random phase: running tick, random refills and requests
        tick_auto = 1'b1;
        rnd_refill = 1'b1;
        for (int k = 0; k < 40; k++) begin
            int len;
            bit lng;
            len = int'($urandom % 256);
            lng = ($urandom % 3 == 0);
            repeat ($urandom % 5) cyc();
            request(len, lng, g);
            if (g) finish_tx(lng, int'($urandom % 6), ($urandom % 4 == 0), -1);
        end
        rnd_refill = 1'b0;
        repeat (3) cyc();

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule